// File: doc/BRIEF.md
# Serial Port with Hardware Flow Control

This block is a full-duplex asynchronous serial port that moves bytes between on-chip logic and an external serial bridge. It holds a receive engine and a transmit engine side by side under one top level. Toward the fabric each direction offers a one-byte valid/ready handshake. Toward the line there is a serial input and a serial output, plus two flow-control pins. The request-to-send output tells the far end that a byte can be accepted. The clear-to-send input decides whether the local transmitter may begin a new frame.

The link runs 8N1: a low start bit, eight data bits least significant first, no parity, and one high stop bit, with the line resting high. The bit period is a compile-time count of clock cycles, and both ends must agree on it. The receiver passes the line through a two-stage synchroniser. It confirms the start bit at half a bit period and then samples every later bit at its centre. A frame whose stop bit reads low raises a one-cycle error pulse, and its byte is dropped.

Top module: `uart_fc_top`

## Requirements
- R1: After synchronous reset, tx_o is high, rx_valid_o is low, rts_o is high, frame_err_o is low, and tx_ready_o is low until cts_i has been high for two clock edges.
- R2: A byte is taken on a clock edge where tx_valid_i and tx_ready_o are both high. From that edge tx_o is low for CLKS_PER_BIT cycles. It then carries data bits 0 through 7, each for CLKS_PER_BIT cycles, and then is high for CLKS_PER_BIT cycles. tx_ready_o stays low for all ten bit periods.
- R3: tx_ready_o is high only while the transmitter is idle and the two-stage synchronised cts_i is high, so it follows cts_i two clock edges late. While cts_i is low no frame starts and tx_o stays high.
- R4: A frame already started is sent in full, with unchanged bit values and timing, even if cts_i goes low partway through it.
- R5: With 8N1 frames on rx_i, the byte, taken least significant bit first, appears on rx_data_o with rx_valid_o high. This happens exactly 3 + CLKS_PER_BIT/2 + 9*CLKS_PER_BIT cycles after the falling edge of the start bit (counted in cycles after the clock edge following it), and not one cycle earlier.
- R6: While rx_valid_o is high and rx_ready_i is low, rx_valid_o and rx_data_o hold their values. After the clock edge where both are high, rx_valid_o is low.
- R7: rts_o is low for as long as a received byte is held unconsumed. It returns high one cycle after the byte is taken.
- R8: If the stop bit is sampled low, frame_err_o is high for exactly one cycle, in the cycle where rx_valid_o would otherwise have risen, and no byte is presented.
- R9: A low pulse on rx_i shorter than half a bit period is rejected as a false start: no byte and no error result from it.
- R10: A frame that completes while an earlier byte is still held is discarded, and the held byte and rx_valid_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| rts_o | output | 1 | High while the receiver can accept a byte |
| cts_i | input | 1 | Far end permits a new transmit frame when high |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i is offered |
| tx_ready_o | output | 1 | Transmitter accepts a byte this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o holds an unconsumed byte |
| rx_ready_i | input | 1 | Fabric takes the held byte |
| frame_err_o | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
Each result has a fixed time after its stimulus. A transmitted bit k occupies the k-th bit period counted from the acceptance edge, so the bench samples tx_o half a bit into each period. A received byte must appear exactly 3 + CLKS_PER_BIT/2 + 9*CLKS_PER_BIT falling edges after the start bit is driven, so the bench checks that rx_valid_o or frame_err_o is still low one falling edge before that point and set exactly on it. tx_ready_o is checked one and two cycles after a cts_i change, and rts_o one cycle after the handshake that frees the receiver. All 256 byte values are swept in both directions with a bit period of eight clocks.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_START = 2'd1,
    SER_DATA  = 2'd2,
    SER_STOP  = 2'd3
  } ser_state_t;

  localparam int unsigned DATA_BITS = 8;
endpackage

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  input  logic                 ready_i,
  output logic                 rts_o,
  output logic                 ferr_o
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned HALF = CLKS_PER_BIT / 2;
  localparam int unsigned IW   = $clog2(DATA_BITS);

  logic                 sync_a, sync_b;
  ser_state_t           st;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;

  // two-stage synchroniser on the asynchronous line
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= line_i;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SER_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      rts_o   <= 1'b1;
      ferr_o  <= 1'b0;
    end else begin
      ferr_o <= 1'b0;
      if (valid_o && ready_i) begin
        valid_o <= 1'b0;
        rts_o   <= 1'b1;
      end
      unique case (st)
        SER_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (!sync_b) st <= SER_START;
        end
        SER_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            st  <= sync_b ? SER_IDLE : SER_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt   <= '0;
            shreg <= {sync_b, shreg[DATA_BITS-1:1]};
            idx   <= idx + 1'b1;
            if (idx == IW'(DATA_BITS - 1)) st <= SER_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_STOP: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            st  <= SER_IDLE;
            if (!sync_b) begin
              ferr_o <= 1'b1;
            end else if (!valid_o) begin
              data_o  <= shreg;
              valid_o <= 1'b1;
              rts_o   <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  input  logic                 cts_i,
  output logic                 line_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW = $clog2(DATA_BITS);

  logic                 cts_a, cts_b;
  ser_state_t           st;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_a <= 1'b0;
      cts_b <= 1'b0;
    end else begin
      cts_a <= cts_i;
      cts_b <= cts_a;
    end
  end

  assign ready_o = (st == SER_IDLE) && cts_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SER_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      line_o <= 1'b1;
    end else begin
      unique case (st)
        SER_IDLE: begin
          if (valid_i && cts_b) begin
            shreg  <= data_i;
            line_o <= 1'b0;
            cnt    <= '0;
            st     <= SER_START;
          end
        end
        SER_START: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt    <= '0;
            idx    <= '0;
            line_o <= shreg[0];
            shreg  <= shreg >> 1;
            st     <= SER_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (idx == IW'(DATA_BITS - 1)) begin
              line_o <= 1'b1;
              st     <= SER_STOP;
            end else begin
              line_o <= shreg[0];
              shreg  <= shreg >> 1;
              idx    <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_STOP: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            st  <= SER_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_top.sv
module uart_fc_top #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       rts_o,
  input  logic       cts_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  output logic       frame_err_o
);
  uart_fc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .line_i  (rx_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .ready_i (rx_ready_i),
    .rts_o   (rts_o),
    .ferr_o  (frame_err_o)
  );

  uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .cts_i   (cts_i),
    .line_o  (tx_o)
  );
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_o,
  input logic       rts_o,
  input logic [7:0] tx_data_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic       frame_err_o
);
  // R2: an accepted byte drives the start bit on the next cycle
  p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid_i && tx_ready_o |=> !tx_o);

  // R2: the transmitter is busy right after accepting
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid_i && tx_ready_o |=> !tx_ready_o);

  // R3: ready is only offered with an idle-high line
  p_ready_idle_line_r3: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> tx_o);

  // R6: held byte stays put until taken
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  // R6: handshake empties the holding register
  p_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o && rx_ready_i |=> !rx_valid_o);

  // R7: request-to-send is withdrawn while a byte is held
  p_rts_held_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> !rts_o);

  // R7: request-to-send returns once the byte is taken
  p_rts_back_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o && rx_ready_i |=> rts_o);

  // R8: error is a single-cycle pulse
  p_ferr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  // R8: a framing error never presents a byte
  p_ferr_no_byte_r8: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> !$rose(rx_valid_o));
endmodule

bind uart_fc_top uart_fc_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_o        (tx_o),
  .rts_o       (rts_o),
  .tx_data_i   (tx_data_i),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ready_i  (rx_ready_i),
  .frame_err_o (frame_err_o)
);

// File: tb/test_uart_fc_top.sv
module test_uart_fc_top;
  localparam int CPB = 8;
  localparam int DUE = 3 + CPB / 2 + 9 * CPB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1;
  logic       tx_o;
  logic       rts_o;
  logic       cts_i = 1'b1;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_ready_i = 1'b0;
  logic       frame_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_fc_top #(.CLKS_PER_BIT(CPB)) i_uart_fc_top (
    .clk(clk), .rst(rst), .rx_i(rx_i), .tx_o(tx_o), .rts_o(rts_o),
    .cts_i(cts_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i), .frame_err_o(frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R2 R4: send one byte, sampling every bit at its centre
  task automatic tx_frame(input logic [7:0] b, input int drop_at);
    logic exp_bit;
    @(negedge clk);
    tx_data_i  = b;
    tx_valid_i = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      repeat (CPB / 2) @(negedge clk);
      exp_bit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      chk(tx_o == exp_bit, (drop_at >= 0) ? "R4 bit" : "R2 bit", tx_o, exp_bit);
      chk(tx_ready_o == 1'b0, "R2 busy", tx_ready_o, 0);
      if (k == drop_at) cts_i = 1'b0;
      repeat (CPB - CPB / 2) @(negedge clk);
    end
    chk(tx_o == 1'b1, "R2 idle", tx_o, 1);
    chk(tx_ready_o == (drop_at < 0), "R3 ready after frame", tx_ready_o, (drop_at < 0));
    if (drop_at >= 0) begin
      cts_i = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  // R5 R8 R10: drive one frame; mode 0 normal, 1 bad stop, 2 receiver already full
  task automatic rx_frame(input logic [7:0] b, input int mode, input logic [7:0] held);
    logic v;
    rx_i = 1'b0;
    for (int t = 1; t <= 10 * CPB; t++) begin
      @(negedge clk);
      if (t % CPB == 0 && t < 10 * CPB) begin
        if (t / CPB == 9) v = (mode == 1) ? 1'b0 : 1'b1;
        else v = b[t/CPB-1];
        rx_i = v;
      end
      if (mode == 0 && t == DUE - 1)
        chk(rx_valid_o == 1'b0, "R5 early", rx_valid_o, 0);
      if (mode == 0 && t == DUE) begin
        chk(rx_valid_o == 1'b1, "R5 valid", rx_valid_o, 1);
        chk(rx_data_o == b, "R5 data", rx_data_o, b);
        chk(rts_o == 1'b0, "R7 rts low", rts_o, 0);
      end
      if (mode == 1 && t == DUE - 1)
        chk(frame_err_o == 1'b0, "R8 early", frame_err_o, 0);
      if (mode == 1 && t == DUE) begin
        chk(frame_err_o == 1'b1, "R8 pulse", frame_err_o, 1);
        chk(rx_valid_o == 1'b0, "R8 no byte", rx_valid_o, 0);
      end
      if (mode == 1 && t == DUE + 1)
        chk(frame_err_o == 1'b0, "R8 one cycle", frame_err_o, 0);
      if (mode == 2 && t == DUE + 1) begin
        chk(rx_data_o == held, "R10 held data", rx_data_o, held);
        chk(rx_valid_o == 1'b1, "R10 held valid", rx_valid_o, 1);
      end
    end
    rx_i = 1'b1;
    if (mode == 1) rx_i = 1'b1;
    @(negedge clk);
  endtask

  // R6 R7: take the held byte
  task automatic take(input logic [7:0] exp);
    chk(rx_valid_o == 1'b1, "R6 valid held", rx_valid_o, 1);
    chk(rx_data_o == exp, "R6 data held", rx_data_o, exp);
    chk(rts_o == 1'b0, "R7 rts while held", rts_o, 0);
    rx_ready_i = 1'b1;
    @(negedge clk);
    rx_ready_i = 1'b0;
    chk(rx_valid_o == 1'b0, "R6 cleared", rx_valid_o, 0);
    chk(rts_o == 1'b1, "R7 rts back", rts_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
    chk(rx_valid_o == 1'b0, "R1 rx empty", rx_valid_o, 0);
    chk(rts_o == 1'b1, "R1 rts", rts_o, 1);
    chk(frame_err_o == 1'b0, "R1 ferr", frame_err_o, 0);
    chk(tx_ready_o == 1'b0, "R1 ready lag", tx_ready_o, 0);
    repeat (2) @(negedge clk);
    chk(tx_ready_o == 1'b1, "R1 ready after sync", tx_ready_o, 1);

    // R2: all byte values
    for (int b = 0; b < 256; b++) tx_frame(8'(b), -1);

    // R3: ready follows cts two edges late, no start while low
    cts_i = 1'b0;
    @(negedge clk);
    chk(tx_ready_o == 1'b1, "R3 lag one", tx_ready_o, 1);
    @(negedge clk);
    chk(tx_ready_o == 1'b0, "R3 lag two", tx_ready_o, 0);
    tx_data_i  = 8'h00;
    tx_valid_i = 1'b1;
    for (int i = 0; i < 4 * CPB; i++) begin
      @(negedge clk);
      chk(tx_o == 1'b1 && tx_ready_o == 1'b0, "R3 blocked", {tx_o, tx_ready_o}, 2);
    end
    tx_valid_i = 1'b0;
    cts_i = 1'b1;
    @(negedge clk);
    chk(tx_ready_o == 1'b0, "R3 rise lag one", tx_ready_o, 0);
    @(negedge clk);
    chk(tx_ready_o == 1'b1, "R3 rise lag two", tx_ready_o, 1);

    // R4: cts drops mid-frame
    tx_frame(8'hA5, 4);
    tx_frame(8'h3C, 0);

    // R5 R6 R7: all byte values received
    for (int b = 0; b < 256; b++) begin
      rx_frame(8'(b), 0, 8'h00);
      repeat (3) @(negedge clk);
      take(8'(b));
    end

    // R8: bad stop bit
    rx_frame(8'h5A, 1, 8'h00);
    repeat (CPB) @(negedge clk);
    chk(rx_valid_o == 1'b0, "R8 discarded", rx_valid_o, 0);
    chk(rts_o == 1'b1, "R8 rts stays", rts_o, 1);

    // R9: short glitch
    rx_i = 1'b0;
    repeat (2) @(negedge clk);
    rx_i = 1'b1;
    for (int i = 0; i < 12 * CPB; i++) begin
      @(negedge clk);
      chk(rx_valid_o == 1'b0 && frame_err_o == 1'b0, "R9 glitch",
          {rx_valid_o, frame_err_o}, 0);
    end

    // R10: overrun drops the newer byte
    rx_frame(8'hC3, 0, 8'h00);
    rx_frame(8'h1E, 2, 8'hC3);
    repeat (2) @(negedge clk);
    take(8'hC3);
    repeat (2) @(negedge clk);
    chk(rx_valid_o == 1'b0, "R10 nothing left", rx_valid_o, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule